// File: doc/BRIEF.md
# Instruction Fetch Loop Buffer

This block sits inside the instruction fetch stage. It keeps one contiguous run of the most recently fetched instruction words, up to `DEPTH` of them, stored in address order. The run is described by a base address and a count of valid words. A fetch request whose address lies inside that run gets its answer from the buffer in the same cycle, with no memory traffic. Any other request goes to a simple memory read port, and the word that comes back is forwarded to the requester. The block then either adds that word to the run or starts a new run with it.

Because only one sequential run is held, finding a word takes a subtraction and a compare, not a tag search. Tight loops and short forward branches whose target falls within the run are served entirely from the buffer. An explicit flush input empties the buffer, for example after code in memory has been rewritten.

Addresses are word addresses: one increment is one instruction word. The requester holds `reqValid` and `reqAddr` steady until it sees `rspValid`.

Top module: `fetch_loop_buf`

## Requirements
- R1: After reset the buffer is empty: the first request misses, and while `reqValid` is low neither `rspValid` nor `memReq` is ever high.
- R2: A request with base <= address < base + count (unsigned, modulo 2^ADDR_W) hits. In that same cycle `rspValid` and `rspHit` are high, `memReq` is low, and `rspData` is the word stored for that address.
- R3: A request outside the window raises `memReq` with `memAddr` equal to `reqAddr`. `rspValid` rises only in a cycle where `memReady` is high, and it comes with `rspHit` low and `rspData` equal to `memData`.
- R4: A miss at exactly base + count (address wrap included) appends the returned word when the buffer is not full. From then on the count is one larger, and every address in the grown window hits.
- R5: A miss at base + count while the buffer is full drops the oldest word and advances the base by one. The previous base address then misses, while the newest `DEPTH` addresses still hit.
- R6: A completed miss at any address other than base + count discards the whole run and starts a new one holding only that word. Addresses from the old run then miss.
- R7: A backward loop jump or a short forward branch to an address inside the window hits, without any memory request.
- R8: While `flush` is high, no request hits and no returned word is stored. After a flush the buffer is empty.
- R9: The count never exceeds `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate every held word |
| reqValid | input | 1 | Fetch request present |
| reqAddr | input | ADDR_W | Word address of the fetch |
| rspValid | output | 1 | Fetch answered this cycle |
| rspData | output | DATA_W | Instruction word returned |
| rspHit | output | 1 | Answer came from the buffer |
| memReq | output | 1 | Memory read requested |
| memAddr | output | ADDR_W | Memory read word address |
| memReady | input | 1 | Memory read data valid this cycle |
| memData | input | DATA_W | Memory read data |

## Verification
The assertions assume that the requester holds `reqAddr` stable until it gets a response, and that `memReady` only rises while `memReq` is high. The bench's driver keeps each request fixed until it sees `rspValid`, then drops it for a cycle. The bench's memory responder raises `memReady` only in response to a pending `memReq`, after zero to three cycles chosen by the low address bits. A flush is held high for the whole of any request it accompanies, so the check on that request sees one consistent buffer state.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic wrEn;    // store the memory word at wrSlot
    logic useBuf;  // answer from storage, not memory
  } lbStrobe_t;
endpackage

// File: rtl/lbuf_ctrl.sv
module lbuf_ctrl
  import lbuf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     flush,
  input  logic                     reqValid,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic                     memReady,
  output lbStrobe_t                strobe,
  output logic [$clog2(DEPTH)-1:0] wrSlot,
  output logic [$clog2(DEPTH)-1:0] rdSlot,
  output logic                     rspValid,
  output logic                     rspHit,
  output logic                     memReq
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] base;
  logic [IDX_W-1:0]  head;
  logic [CNT_W-1:0]  count;

  logic [ADDR_W-1:0] offset;
  logic inWin, contig, isFull, missDone;

  always_comb begin
    offset   = reqAddr - base;
    inWin    = !flush && (offset < ADDR_W'(count));
    contig   = (offset == ADDR_W'(count));
    isFull   = (count == CNT_W'(DEPTH));
    memReq   = reqValid && !inWin;
    missDone = memReq && memReady;
    rspHit   = reqValid && inWin;
    rspValid = rspHit || missDone;
    rdSlot   = head + offset[IDX_W-1:0];
    wrSlot   = contig ? head + count[IDX_W-1:0] : '0;
    strobe.wrEn   = missDone && !flush;
    strobe.useBuf = rspHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      base  <= '0;
      head  <= '0;
      count <= '0;
    end else if (flush) begin
      count <= '0;
    end else if (missDone) begin
      if (contig) begin
        if (isFull) begin
          base <= base + 1'b1;
          head <= head + 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end else begin
        base  <= reqAddr;
        head  <= '0;
        count <= CNT_W'(1);
      end
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!rspValid && !memReq));
  // R3
  miss_needs_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> memReady);
  // R5
  full_slide_chk: assert property (@(posedge clk) disable iff (!rstN)
    (missDone && contig && isFull && !flush) |=> (base == $past(base) + 1'b1 && count == CNT_W'(DEPTH)));
  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (missDone && !contig && !flush) |=> (count == CNT_W'(1) && base == $past(reqAddr)));
  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0));
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/lbuf_data.sv
module lbuf_data
  import lbuf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                     clk,
  input  lbStrobe_t                strobe,
  input  logic [$clog2(DEPTH)-1:0] wrSlot,
  input  logic [$clog2(DEPTH)-1:0] rdSlot,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rspData
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) store[wrSlot] <= wrData;
  end

  assign rspData = strobe.useBuf ? store[rdSlot] : wrData;
endmodule

// File: rtl/fetch_loop_buf.sv
module fetch_loop_buf
  import lbuf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspHit,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memData
);
  localparam int IDX_W = $clog2(DEPTH);

  lbStrobe_t        strobe;
  logic [IDX_W-1:0] wrSlot, rdSlot;

  assign memAddr = reqAddr;

  lbuf_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) ctrl (
    .clk(clk), .rstN(rstN), .flush(flush), .reqValid(reqValid),
    .reqAddr(reqAddr), .memReady(memReady), .strobe(strobe),
    .wrSlot(wrSlot), .rdSlot(rdSlot), .rspValid(rspValid),
    .rspHit(rspHit), .memReq(memReq)
  );

  lbuf_data #(.DATA_W(DATA_W), .DEPTH(DEPTH)) data (
    .clk(clk), .strobe(strobe), .wrSlot(wrSlot), .rdSlot(rdSlot),
    .wrData(memData), .rspData(rspData)
  );

  // R2
  hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> (rspValid && !memReq));
endmodule

// File: tb/fetch_loop_buf_test.sv
module fetch_loop_buf_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 0, rstN = 0, flush = 0, reqValid = 0, memReady = 0;
  logic [31:0] reqAddr = '0, memData = '0, rspData, memAddr;
  logic rspValid, rspHit, memReq;

  fetch_loop_buf #(.ADDR_W(32), .DATA_W(32), .DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .flush(flush), .reqValid(reqValid),
    .reqAddr(reqAddr), .rspValid(rspValid), .rspData(rspData),
    .rspHit(rspHit), .memReq(memReq), .memAddr(memAddr),
    .memReady(memReady), .memData(memData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    logic        hit;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0, bad = 0, cycles = 0;
  bit done = 0;
  logic [31:0] mBase = 0;
  int mCount = 0;

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic report;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // memory responder: latency of addr[1:0] cycles
  bit busy = 0;
  int waitLeft = 0;
  initial forever begin
    @(negedge clk);
    if (memReq) begin
      if (!busy) begin busy = 1; waitLeft = int'(memAddr[1:0]); end
      if (waitLeft == 0) begin memReady = 1; memData = memWord(memAddr); end
      else waitLeft--;
    end
    @(posedge clk); #1;
    if (memReady) busy = 0;
    memReady = 0;
  end

  // monitor: pops expected items as responses appear
  initial forever begin
    @(negedge clk); #2;
    if (rstN && rspValid) begin
      expItem_t e;
      total++;
      if (expQ.size() == 0) begin
        bad++; $display("FAIL R1: unexpected response act=%h exp=none", rspData);
      end else begin
        e = expQ.pop_front();
        if (rspData !== e.data || rspHit !== e.hit) begin
          bad++;
          $display("FAIL %s: addr=%h data act=%h exp=%h hit act=%b exp=%b",
                   e.tag, e.addr, rspData, e.data, rspHit, e.hit);
        end
        if (!e.hit && memAddr !== e.addr) begin
          bad++; $display("FAIL R3: memAddr act=%h exp=%h", memAddr, e.addr);
        end
        if (rspHit && memReq) begin
          bad++; $display("FAIL R2: memReq act=1 exp=0 on hit addr=%h", e.addr);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      bad++; $display("FAIL watchdog: cycles act=%0d exp<=100000", cycles);
      report();
    end
  end

  task automatic fetch(input logic [31:0] a, input string tag, input bit withFlush = 0);
    expItem_t e;
    bit expHit;
    expHit = !withFlush && ((a - mBase) < 32'(mCount));
    e.addr = a; e.data = memWord(a); e.hit = expHit; e.tag = tag;
    expQ.push_back(e);
    @(posedge clk); #1;
    reqValid = 1; reqAddr = a; flush = withFlush;
    do begin @(negedge clk); #3; end while (!rspValid);
    if (withFlush) mCount = 0;
    else if (!expHit) begin
      if (a == mBase + 32'(mCount)) begin
        if (mCount == DEPTH) mBase = mBase + 1;
        else mCount++;
      end else begin
        mBase = a; mCount = 1;
      end
    end
    @(posedge clk); #1;
    reqValid = 0; flush = 0;
  endtask

  initial begin
    // R1: quiet outputs under reset and idle
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    total++;
    if (rspValid !== 0 || memReq !== 0) begin
      bad++; $display("FAIL R1: rspValid/memReq act=%b%b exp=00", rspValid, memReq);
    end
    @(posedge clk); #1 rstN = 1;
    @(negedge clk); #2;
    total++;
    if (rspValid !== 0 || memReq !== 0) begin
      bad++; $display("FAIL R1: idle outputs act=%b%b exp=00", rspValid, memReq);
    end
    fetch(32'd100, "R1");
    // R4: grow the run to full
    for (int i = 1; i < DEPTH; i++) fetch(32'd100 + 32'(i), "R4");
    // R2: every held word hits
    for (int i = 0; i < DEPTH; i++) fetch(32'd100 + 32'(i), "R2");
    // R7: loop back and short forward branch inside window
    fetch(32'd105, "R7"); fetch(32'd109, "R7"); fetch(32'd103, "R7");
    // R5: full append slides the window
    fetch(32'd116, "R5"); fetch(32'd101, "R5"); fetch(32'd116, "R5");
    fetch(32'd100, "R5");
    // R6: restart at 100 dropped the old run
    fetch(32'd102, "R6"); fetch(32'd102, "R6");
    // R8: flush alone, then request with flush held
    fetch(32'd103, "R6");
    @(posedge clk); #1 flush = 1;
    @(posedge clk); #1 flush = 0; mCount = 0;
    fetch(32'd102, "R8");
    fetch(32'd102, "R8", 1);
    fetch(32'd102, "R8");
    // R4: append across address wrap
    fetch(32'hFFFF_FFFE, "R6"); fetch(32'hFFFF_FFFF, "R4");
    fetch(32'h0000_0000, "R4"); fetch(32'h0000_0001, "R4");
    fetch(32'hFFFF_FFFE, "R2"); fetch(32'h0000_0000, "R2");
    // R9 / R5: long run wraps the circular slots several times
    for (int i = 0; i < 40; i++) fetch(32'd300 + 32'(i), "R5");
    for (int i = 24; i < 40; i++) fetch(32'd300 + 32'(i), "R9");
    fetch(32'd323, "R5");
    repeat (4) @(posedge clk);
    if (expQ.size() != 0) begin
      total++; bad++;
      $display("FAIL R3: pending responses act=%0d exp=0", expQ.size());
    end
    done = 1;
    report();
  end
endmodule